// File: doc/BRIEF.md
# Microcoded Instruction Sequencer

This block is the control engine of a small accumulator machine. A control address register selects one word of an on-chip microcode store. That word drives an 18-bit control bus and a 4-bit ALU operation code directly in the same cycle, with no output register between the store and the pins. The datapath registers that obey these lines are not part of the block. The datapath supplies two inputs: the 8-bit opcode held in its instruction register and the sign bit of its accumulator.

Three bits in every microword decide the next control address. Bit 0 advances to the following word. Bit 1 jumps to the routine that belongs to the current opcode. Bit 2 returns to address 0, where the shared instruction fetch routine starts. The routine chosen for the conditional jump depends on the accumulator sign. A halt opcode leads to a word that loops on itself and raises a halt output.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the control address at 0. In the cycle after any reset edge the outputs show the first fetch word: control bits 11 and 0 set and nothing else, ALU code 0, halt low.
- R2: Fetch runs as four words in this order: {11,0}; {3,6,0}; {7,12,0}; {8,1}. The fourth word dispatches on the opcode.
- R3: Exactly one of control bits 0, 1 and 2 is set in every microword that is executed.
- R4: The memory-operand ALU opcodes are 0x01 add, 0x02 sub, 0x03 and, 0x04 or, 0x05 not, 0x08 multiply and 0x09 divide. Each runs three words: {3,6,0}, then {9,0}, then {13,14,15,2}. For 0x05 the third word is {13,15,2}, with no bit 14. The third word carries an ALU code equal to the opcode.
- R5: Shift right (0x06) and shift left (0x07) each run a single word {14,15,2}, with ALU code 6 or 7.
- R6: Load (0x0E) runs {3,6,0}, {9,0}, {16,2}. Store (0x0D) runs {17,0}, {4,5,2}.
- R7: The unconditional jump (0x0B) runs one word {10,2}.
- R8: The conditional jump (0x0A) runs {10,2} when the accumulator sign input is 0, and {2} alone when it is 1.
- R9: Halt (0x0C) runs the word {1} with the halt output high. It repeats that word every cycle until reset.
- R10: Any other opcode runs the single word {2}.
- R11: The ALU code is 0 in every word that does not set control bit 15.
- R12: The opcode input matters only in the dispatch cycle. Changing it during the first three fetch words has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Opcode from the instruction register |
| acc_neg | input | 1 | Accumulator sign bit |
| ctrl | output | 18 | Control bus of the current microword |
| alu_fn | output | 4 | ALU operation code of the current microword |
| halted | output | 1 | High while the halt word executes |

## Verification
Every defined opcode is run through a full fetch and routine, and the control bus and ALU code are compared with a reference every cycle. These runs distinguish the shared three-step operand routines by their final ALU code alone. The conditional jump is run with both sign values, which shows that the sign input selects between the two routines. Undefined opcodes at both ends of the byte range confirm the fall-back word. A fetch whose opcode carries halt until the dispatch cycle shows that the opcode is read only at dispatch. A reset in the middle of a routine and a reset out of the halt loop confirm the return to address 0.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int CTRL_W = 18;
  localparam int ALU_W  = 4;

  // control bit positions
  localparam int B_INC     = 0;
  localparam int B_MAP     = 1;
  localparam int B_ZERO    = 2;
  localparam int B_MRD     = 3;
  localparam int B_MDRV    = 4;
  localparam int B_MWR     = 5;
  localparam int B_MBR_MEM = 6;
  localparam int B_IR_LD   = 7;
  localparam int B_MAR_MBR = 8;
  localparam int B_BR_LD   = 9;
  localparam int B_PC_LD   = 10;
  localparam int B_MAR_PC  = 11;
  localparam int B_PC_INC  = 12;
  localparam int B_ALU_BR  = 13;
  localparam int B_ALU_ACC = 14;
  localparam int B_ACC_ALU = 15;
  localparam int B_ACC_BR  = 16;
  localparam int B_MBR_ACC = 17;

  // opcodes decoded at dispatch
  localparam logic [7:0] OP_ADD   = 8'h01;
  localparam logic [7:0] OP_SUB   = 8'h02;
  localparam logic [7:0] OP_AND   = 8'h03;
  localparam logic [7:0] OP_OR    = 8'h04;
  localparam logic [7:0] OP_NOT   = 8'h05;
  localparam logic [7:0] OP_SHR   = 8'h06;
  localparam logic [7:0] OP_SHL   = 8'h07;
  localparam logic [7:0] OP_MPY   = 8'h08;
  localparam logic [7:0] OP_DIV   = 8'h09;
  localparam logic [7:0] OP_JGEZ  = 8'h0A;
  localparam logic [7:0] OP_JMP   = 8'h0B;
  localparam logic [7:0] OP_HALT  = 8'h0C;
  localparam logic [7:0] OP_STORE = 8'h0D;
  localparam logic [7:0] OP_LOAD  = 8'h0E;

  // microcode layout
  localparam int A_FETCH  = 0;
  localparam int FETCH_N  = 4;
  localparam int A_IDLE   = 4;
  localparam int A_JMP    = 5;
  localparam int A_HALT   = 6;
  localparam int A_SHR    = 7;
  localparam int A_SHL    = 8;
  localparam int A_STORE  = 9;
  localparam int A_LOAD   = 11;
  localparam int A_ARITH  = 14;
  localparam int ARITH_N  = 7;
  localparam int ARITH_LEN = 3;
  localparam int A_END    = A_ARITH + ARITH_N * ARITH_LEN;

  typedef struct packed {
    logic              halt;
    logic [ALU_W-1:0]  alu;
    logic [CTRL_W-1:0] ctrl;
  } uword_t;

  function automatic logic [CTRL_W-1:0] cbit(input int n);
    return CTRL_W'(1) << n;
  endfunction

  // slot of a memory-operand ALU opcode, -1 when none
  function automatic int arith_slot(input logic [7:0] op);
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOT: return int'(op) - 1;
      OP_MPY:  return 5;
      OP_DIV:  return 6;
      default: return -1;
    endcase
  endfunction

  function automatic logic [ALU_W-1:0] slot_alu(input int slot);
    return (slot < 5) ? ALU_W'(slot + 1) : ALU_W'(slot + 3);
  endfunction

  // microcode contents, evaluated per address at elaboration
  function automatic uword_t uword_at(input int a);
    uword_t w;
    int slot;
    int step;
    w = '0;
    if (a == 0) begin
      w.ctrl = cbit(B_MAR_PC) | cbit(B_INC);
    end else if (a == 1) begin
      w.ctrl = cbit(B_MRD) | cbit(B_MBR_MEM) | cbit(B_INC);
    end else if (a == 2) begin
      w.ctrl = cbit(B_IR_LD) | cbit(B_PC_INC) | cbit(B_INC);
    end else if (a == 3) begin
      w.ctrl = cbit(B_MAR_MBR) | cbit(B_MAP);
    end else if (a == A_JMP) begin
      w.ctrl = cbit(B_PC_LD) | cbit(B_ZERO);
    end else if (a == A_HALT) begin
      w.ctrl = cbit(B_MAP);
      w.halt = 1'b1;
    end else if (a == A_SHR || a == A_SHL) begin
      w.ctrl = cbit(B_ALU_ACC) | cbit(B_ACC_ALU) | cbit(B_ZERO);
      w.alu  = (a == A_SHR) ? ALU_W'(6) : ALU_W'(7);
    end else if (a == A_STORE) begin
      w.ctrl = cbit(B_MBR_ACC) | cbit(B_INC);
    end else if (a == A_STORE + 1) begin
      w.ctrl = cbit(B_MDRV) | cbit(B_MWR) | cbit(B_ZERO);
    end else if (a == A_LOAD) begin
      w.ctrl = cbit(B_MRD) | cbit(B_MBR_MEM) | cbit(B_INC);
    end else if (a == A_LOAD + 1) begin
      w.ctrl = cbit(B_BR_LD) | cbit(B_INC);
    end else if (a == A_LOAD + 2) begin
      w.ctrl = cbit(B_ACC_BR) | cbit(B_ZERO);
    end else if (a >= A_ARITH && a < A_END) begin
      slot = (a - A_ARITH) / ARITH_LEN;
      step = (a - A_ARITH) % ARITH_LEN;
      if (step == 0) begin
        w.ctrl = cbit(B_MRD) | cbit(B_MBR_MEM) | cbit(B_INC);
      end else if (step == 1) begin
        w.ctrl = cbit(B_BR_LD) | cbit(B_INC);
      end else begin
        w.ctrl = cbit(B_ALU_BR) | cbit(B_ACC_ALU) | cbit(B_ZERO);
        if (slot != 4) w.ctrl = w.ctrl | cbit(B_ALU_ACC);
        w.alu = slot_alu(slot);
      end
    end else begin
      w.ctrl = cbit(B_ZERO);
    end
    return w;
  endfunction

  // routine entry for an opcode and accumulator sign
  function automatic int dispatch_addr(input logic [7:0] op, input logic neg);
    int slot;
    slot = arith_slot(op);
    if (slot >= 0) return A_ARITH + ARITH_LEN * slot;
    case (op)
      OP_SHR:   return A_SHR;
      OP_SHL:   return A_SHL;
      OP_JMP:   return A_JMP;
      OP_JGEZ:  return neg ? A_IDLE : A_JMP;
      OP_HALT:  return A_HALT;
      OP_STORE: return A_STORE;
      OP_LOAD:  return A_LOAD;
      default:  return A_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);
  localparam int DEPTH = 1 << ADDR_W;

  uword_t store [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign store[a] = uword_at(a);
  end

  assign word = store[addr];
endmodule

// File: rtl/useq_map.sv
module useq_map
  import useq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [7:0]        opcode,
  input  logic              acc_neg,
  output logic [ADDR_W-1:0] target
);
  always_comb target = ADDR_W'(dispatch_addr(opcode, acc_neg));
endmodule

// File: rtl/useq_next.sv
module useq_next #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_inc,
  input  logic              sel_map,
  input  logic              sel_zero,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] car
);
  logic [ADDR_W-1:0] car_nx;

  always_comb begin
    case ({sel_zero, sel_map, sel_inc})
      3'b001:  car_nx = car + ADDR_W'(1);
      3'b010:  car_nx = target;
      3'b100:  car_nx = '0;
      default: car_nx = car;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) car <= '0;
    else     car <= car_nx;
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  opcode,
  input  logic        acc_neg,
  output logic [17:0] ctrl,
  output logic [3:0]  alu_fn,
  output logic        halted
);
  uword_t            cur;
  logic [ADDR_W-1:0] car;
  logic [ADDR_W-1:0] disp_target;
  logic              seq_inc;
  logic              seq_map;
  logic              seq_zero;

  useq_rom #(.ADDR_W(ADDR_W)) u_rom (
    .addr (car),
    .word (cur)
  );

  useq_map #(.ADDR_W(ADDR_W)) u_map (
    .opcode  (opcode),
    .acc_neg (acc_neg),
    .target  (disp_target)
  );

  assign seq_inc  = cur.ctrl[B_INC];
  assign seq_map  = cur.ctrl[B_MAP];
  assign seq_zero = cur.ctrl[B_ZERO];

  useq_next #(.ADDR_W(ADDR_W)) u_next (
    .clk      (clk),
    .rst      (rst),
    .sel_inc  (seq_inc),
    .sel_map  (seq_map),
    .sel_zero (seq_zero),
    .target   (disp_target),
    .car      (car)
  );

  assign ctrl   = cur.ctrl;
  assign alu_fn = cur.alu;
  assign halted = cur.halt;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        opcode,
  input logic              acc_neg,
  input logic [17:0]       ctrl,
  input logic [3:0]        alu_fn,
  input logic              halted,
  input logic              seq_inc,
  input logic              seq_map,
  input logic [ADDR_W-1:0] car
);
  // R1
  reset_home_chk: assert property (@(posedge clk) rst |=> (car == '0 && ctrl[11] && ctrl[0]));

  // R3
  one_sel_chk: assert property (@(posedge clk) disable iff (rst) $countones(ctrl[2:0]) == 1);

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    seq_inc |=> car == $past(car) + ADDR_W'(1));

  // R8
  jgez_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_map && !halted && opcode == 8'h0A && acc_neg) |=> !ctrl[10]);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst) halted |=> halted);

  // R11
  alu_quiet_chk: assert property (@(posedge clk) disable iff (rst) !ctrl[15] |-> alu_fn == 4'd0);
endmodule

bind useq_ctrl useq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .opcode  (opcode),
  .acc_neg (acc_neg),
  .ctrl    (ctrl),
  .alu_fn  (alu_fn),
  .halted  (halted),
  .seq_inc (seq_inc),
  .seq_map (seq_map),
  .car     (car)
);

// File: tb/useq_ctrl_tb.sv
module useq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  opcode = 8'h00;
  logic        acc_neg = 1'b0;
  logic [17:0] ctrl;
  logic [3:0]  alu_fn;
  logic        halted;

  int checks = 0;
  int failures = 0;

  logic [17:0] qc[$];
  logic [3:0]  qa[$];
  logic        qh[$];
  string       qt[$];

  always #5 clk = ~clk;

  useq_ctrl u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .acc_neg(acc_neg),
    .ctrl(ctrl), .alu_fn(alu_fn), .halted(halted)
  );

  function automatic logic [17:0] bb(input int n);
    return 18'd1 << n;
  endfunction

  task automatic push(input logic [17:0] c, input logic [3:0] a, input logic h, input string t);
    qc.push_back(c); qa.push_back(a); qh.push_back(h); qt.push_back(t);
  endtask

  task automatic expect_now(input logic [17:0] c, input logic [3:0] a, input logic h, input string t);
    checks++;
    if (ctrl !== c || alu_fn !== a || halted !== h) begin
      failures++;
      $display("FAIL %s ctrl=%h alu=%0d halt=%b expected ctrl=%h alu=%0d halt=%b",
               t, ctrl, alu_fn, halted, c, a, h);
    end
    checks++;
    if ($countones(ctrl[2:0]) != 1) begin
      failures++;
      $display("FAIL R3 select bits=%b expected exactly one set", ctrl[2:0]);
    end
  endtask

  // reference model: expected microwords of one instruction
  task automatic build(input logic [7:0] op, input logic neg);
    qc.delete(); qa.delete(); qh.delete(); qt.delete();
    push(bb(11) | bb(0), 0, 0, "R2");
    push(bb(3) | bb(6) | bb(0), 0, 0, "R2");
    push(bb(7) | bb(12) | bb(0), 0, 0, "R2");
    push(bb(8) | bb(1), 0, 0, "R2");
    case (op)
      8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h08, 8'h09: begin
        push(bb(3) | bb(6) | bb(0), 0, 0, "R4");
        push(bb(9) | bb(0), 0, 0, "R4");
        push(bb(13) | bb(15) | bb(2) | (op == 8'h05 ? 18'd0 : bb(14)), op[3:0], 0, "R4");
      end
      8'h06, 8'h07: push(bb(14) | bb(15) | bb(2), op[3:0], 0, "R5");
      8'h0E: begin
        push(bb(3) | bb(6) | bb(0), 0, 0, "R6");
        push(bb(9) | bb(0), 0, 0, "R6");
        push(bb(16) | bb(2), 0, 0, "R6");
      end
      8'h0D: begin
        push(bb(17) | bb(0), 0, 0, "R6");
        push(bb(4) | bb(5) | bb(2), 0, 0, "R6");
      end
      8'h0B: push(bb(10) | bb(2), 0, 0, "R7");
      8'h0A: push(neg ? bb(2) : (bb(10) | bb(2)), 0, 0, "R8");
      8'h0C: push(bb(1), 0, 1, "R9");
      default: push(bb(2), 0, 0, "R10");
    endcase
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    expect_now(bb(11) | bb(0), 0, 0, "R1");
    rst = 1'b0;
  endtask

  // entered at a negedge showing the first fetch word
  task automatic run(input logic [7:0] op, input logic neg, input logic [7:0] early, input int cut);
    build(op, neg);
    acc_neg = neg;
    opcode = early;
    for (int i = 0; i < qc.size(); i++) begin
      if (i > 0) @(negedge clk);
      if (i == cut) begin
        do_reset();
        return;
      end
      if (i == 3) opcode = op;
      expect_now(qc[i], qa[i], qh[i], (early != op && i >= 3) ? "R12" : qt[i]);
    end
    if (op == 8'h0C) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        expect_now(bb(1), 0, 1, "R9");
      end
      @(negedge clk);
      do_reset();
      return;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    run(8'h01, 0, 8'h01, -1);
    run(8'h02, 1, 8'h02, -1);
    run(8'h03, 0, 8'h03, -1);
    run(8'h04, 0, 8'h04, -1);
    run(8'h05, 0, 8'h05, -1);
    run(8'h08, 0, 8'h08, -1);
    run(8'h09, 1, 8'h09, -1);
    run(8'h06, 0, 8'h06, -1);
    run(8'h07, 0, 8'h07, -1);
    run(8'h0E, 0, 8'h0E, -1);
    run(8'h0D, 0, 8'h0D, -1);
    run(8'h0B, 0, 8'h0B, -1);
    run(8'h0A, 0, 8'h0A, -1);
    run(8'h0A, 1, 8'h0A, -1);
    run(8'h00, 0, 8'h00, -1);
    run(8'hFF, 0, 8'hFF, -1);
    run(8'h0F, 1, 8'h0F, -1);
    run(8'h01, 0, 8'h0C, -1);
    run(8'h0B, 0, 8'h0A, -1);
    run(8'h0E, 0, 8'h0E, 5);
    run(8'h02, 0, 8'h02, -1);
    run(8'h0C, 0, 8'h0C, -1);
    run(8'h07, 0, 8'h07, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule